// File: doc/BRIEF.md
# Dual-Path Serial ADC Readout Controller

This controller sits on the host side of a simultaneous-sampling converter that has two conversion paths, A and B. Each path multiplexes two differential inputs, index 0 and index 1. The controller produces the conversion clock, a convert strobe, a read strobe, an active-low select and three mode pins. It shifts in the 20-bit serial words that come back and presents each 16-bit result on a valid/ready output, tagged with its path and input index.

While `run` is high, the controller performs back-to-back sample periods. Configuration is taken from `cfg_four_ch`, `cfg_pair_sel` and `cfg_one_line` only when a period begins. In the two-channel schedule a fixed pair is converted. In the four-channel schedule the pairs alternate. In dual-line readout the two words arrive in parallel on two lines. In single-line readout both words arrive one after the other on line A, so a sample period takes twice as long. Each word's 4-bit channel tag is checked against the schedule.

The output stage holds a result until the consumer accepts it. Results that complete while an earlier one is still waiting are dropped and counted.

Top module: `adc_pair_reader`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `adc_cs_n` is 1, `adc_clk`, `adc_convst` and `adc_rd` are 0, `res_valid` is 0 and `ovf_count` is 0.
- R2: During a period `adc_clk` toggles on every system clock. A period begins with `adc_convst` and `adc_rd` rising together for the first two system cycles. A dual-line period lasts 40 system cycles (20 conversion clocks). A single-line period lasts 80 system cycles (40 conversion clocks).
- R3: A serial bit is taken on each falling `adc_clk` edge, with the first bit taken on the first falling edge after `adc_rd` rises. Each 20-bit word is a 4-bit tag followed by 16 data bits, both MSB first.
- R4: In the two-channel schedule (`cfg_four_ch`=0), `cfg_pair_sel` selects the input index converted on both paths. The result carries `res_path` (0=A, 1=B) and `res_idx`.
- R5: In the four-channel schedule, the index alternates 0,1,0,1 from one period to the next. It restarts at 0 after an idle gap and after any two-channel period.
- R6: In dual-line mode (`cfg_one_line`=0), the path A word comes on `sdata_a` and the path B word comes on `sdata_b`. The A result is output before the B result.
- R7: In single-line mode, `sdata_a` carries the A word and then the B word (40 bits), and `sdata_b` is ignored. A is output first.
- R8: The expected tag is binary {1,0,path,index}. `res_err` is 1 exactly for results whose received tag differs from it.
- R9: Configuration inputs are sampled only when a period begins. `adc_m0`, `adc_m1` and `adc_a0` show the sampled values and stay constant for the whole period.
- R10: While `res_valid`=1 and `res_ready`=0, `res_valid` and all result fields stay unchanged.
- R11: If a period completes while any result is still pending, both of its results are dropped and `ovf_count` increases by 2, saturating at its maximum.
- R12: If `run` is low when a period ends, `adc_cs_n` goes to 1 and `adc_clk`, `adc_rd` and `adc_convst` stay 0 until `run` starts a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep performing sample periods |
| cfg_four_ch | input | 1 | 1 = alternating four-channel schedule |
| cfg_pair_sel | input | 1 | Input index in two-channel schedule |
| cfg_one_line | input | 1 | 1 = both words on line A |
| sdata_a | input | 1 | Serial data line A |
| sdata_b | input | 1 | Serial data line B |
| adc_clk | output | 1 | Conversion clock (system clock / 2) |
| adc_convst | output | 1 | Convert strobe |
| adc_rd | output | 1 | Read synchronisation strobe |
| adc_cs_n | output | 1 | Active-low select |
| adc_m0 | output | 1 | Schedule mode pin |
| adc_a0 | output | 1 | Pair select pin |
| adc_m1 | output | 1 | Readout line mode pin |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | 16 | Conversion result |
| res_path | output | 1 | 0 = path A, 1 = path B |
| res_idx | output | 1 | Input index of the result |
| res_err | output | 1 | Tag mismatch on this result |
| ovf_count | output | OVF_W | Dropped result count, saturating |

## Verification
The assertions check the following on every cycle:
- the result stays stable while stalled;
- the mode pins are frozen within a period;
- `adc_convst` rises together with `adc_rd`;
- the conversion clock toggles continuously during a period and is quiet when idle;
- the overflow count never decreases.

The remaining behaviour can only be shown by the bench's scenarios, which run a converter model over every mode combination:
- bit ordering and word splitting in both readout modes;
- the alternating index sequence and its restart;
- exact period lengths;
- tag mismatch flagging;
- the drop-and-saturate accounting.

// File: rtl/adcrd_pkg.sv
// Shared constants and the result record used by the readout controller.
// Assumes a 4-bit tag followed by a 16-bit sample in each serial word.
package adcrd_pkg;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int WORD_W = TAG_W + DATA_W;

    typedef struct packed {
        logic              path;
        logic              idx;
        logic              err;
        logic [DATA_W-1:0] data;
    } adcrd_res_t;
endpackage

// File: rtl/adcrd_seq.sv
// Period sequencer: makes the conversion clock (system clock / 2), the
// convert/read strobes, the select and the latched mode pins. It also tracks
// the input index of each period. Assumes `run` and the configuration inputs
// are synchronous to clk.
module adcrd_seq #(
    parameter int WORD_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cfg_four_ch,
    input  logic cfg_pair_sel,
    input  logic cfg_one_line,
    output logic adc_clk,
    output logic adc_convst,
    output logic adc_rd,
    output logic adc_cs_n,
    output logic adc_m0,
    output logic adc_a0,
    output logic adc_m1,
    output logic sample_en,
    output logic period_end,
    output logic cur_idx
);
    localparam int CNT_W = $clog2(2 * WORD_W);
    localparam logic [CNT_W-1:0] LAST_DUAL = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(2 * WORD_W - 1);

    logic             active, ph, nxt_idx;
    logic [CNT_W-1:0] bitcnt;
    logic             last_bit, start_now;

    // Decode the last capture edge of a period and the start condition.
    always_comb begin
        last_bit   = (bitcnt == (adc_m1 ? LAST_ONE : LAST_DUAL));
        sample_en  = active & ph;
        period_end = sample_en & last_bit;
        start_now  = run & (~active | period_end);
    end

    // Advance the period state, strobes, latched configuration and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            ph         <= 1'b0;
            bitcnt     <= '0;
            adc_convst <= 1'b0;
            adc_rd     <= 1'b0;
            adc_m0     <= 1'b0;
            adc_m1     <= 1'b0;
            adc_a0     <= 1'b0;
            cur_idx    <= 1'b0;
            nxt_idx    <= 1'b0;
        end else if (start_now) begin
            active     <= 1'b1;
            ph         <= 1'b0;
            bitcnt     <= '0;
            adc_convst <= 1'b1;
            adc_rd     <= 1'b1;
            adc_m0     <= cfg_four_ch;
            adc_m1     <= cfg_one_line;
            adc_a0     <= cfg_pair_sel;
            if (cfg_four_ch) begin
                cur_idx <= nxt_idx;
                nxt_idx <= ~nxt_idx;
            end else begin
                cur_idx <= cfg_pair_sel;
                nxt_idx <= 1'b0;
            end
        end else if (period_end) begin
            active  <= 1'b0;
            ph      <= 1'b0;
            nxt_idx <= 1'b0;
        end else if (active) begin
            ph <= ~ph;
            if (ph) begin
                bitcnt     <= bitcnt + 1'b1;
                adc_convst <= 1'b0;
                adc_rd     <= 1'b0;
            end
        end
    end

    assign adc_clk  = ph;
    assign adc_cs_n = ~active;
endmodule

// File: rtl/adcrd_shift.sv
// Capture shifters: one register per serial line, shifted on each capture
// edge. Line A is long enough for two words (single-line readout). The full
// word views include the bit arriving on the current edge.
module adcrd_shift #(
    parameter int WORD_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic                  sdata_a,
    input  logic                  sdata_b,
    output logic [2*WORD_W-1:0]   full_a,
    output logic [WORD_W-1:0]     full_b
);
    localparam int LEN_A = 2 * WORD_W;

    logic [LEN_A-1:0]  sr_a;
    logic [WORD_W-1:0] sr_b;

    // Shift both lines on each falling conversion-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_a <= '0;
            sr_b <= '0;
        end else if (sample_en) begin
            sr_a <= {sr_a[LEN_A-2:0], sdata_a};
            sr_b <= {sr_b[WORD_W-2:0], sdata_b};
        end
    end

    assign full_a = {sr_a[LEN_A-2:0], sdata_a};
    assign full_b = {sr_b[WORD_W-2:0], sdata_b};
endmodule

// File: rtl/adcrd_outq.sv
// Two-slot result holder. It loads the A and B results of a period together
// when empty and emits A and then B on valid/ready. A period arriving while
// anything is pending is dropped and counted, saturating.
module adcrd_outq
    import adcrd_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  adcrd_res_t       res_a,
    input  adcrd_res_t       res_b,
    input  logic             ready,
    output logic             valid,
    output adcrd_res_t       res,
    output logic [OVF_W-1:0] ovf
);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;
    localparam logic [OVF_W-1:0] OVF_LIM = OVF_MAX - OVF_W'(2);

    adcrd_res_t slot0, slot1;
    logic [1:0] cnt;
    logic       head;

    assign valid = (cnt != 2'd0);
    assign res   = head ? slot1 : slot0;

    // Load, pop and drop accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0 <= '0;
            slot1 <= '0;
            cnt   <= 2'd0;
            head  <= 1'b0;
            ovf   <= '0;
        end else begin
            if (push && cnt == 2'd0) begin
                slot0 <= res_a;
                slot1 <= res_b;
                cnt   <= 2'd2;
                head  <= 1'b0;
            end else if (valid && ready) begin
                cnt  <= cnt - 2'd1;
                head <= ~head;
            end
            if (push && cnt != 2'd0)
                ovf <= (ovf > OVF_LIM) ? OVF_MAX : ovf + OVF_W'(2);
        end
    end
endmodule

// File: rtl/adc_pair_reader.sv
// Top of the dual-path serial ADC readout controller. It joins the sequencer,
// the capture shifters and the result holder, splits the words for the
// selected readout mode and checks each tag against the schedule.
module adc_pair_reader
    import adcrd_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_four_ch,
    input  logic              cfg_pair_sel,
    input  logic              cfg_one_line,
    input  logic              sdata_a,
    input  logic              sdata_b,
    output logic              adc_clk,
    output logic              adc_convst,
    output logic              adc_rd,
    output logic              adc_cs_n,
    output logic              adc_m0,
    output logic              adc_a0,
    output logic              adc_m1,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              res_path,
    output logic              res_idx,
    output logic              res_err,
    output logic [OVF_W-1:0]  ovf_count
);
    logic                  sample_en, period_end, cur_idx;
    logic [2*WORD_W-1:0]   full_a;
    logic [WORD_W-1:0]     full_b;
    logic [WORD_W-1:0]     word_a, word_b;
    adcrd_res_t            res_a, res_b, res_q;

    adcrd_seq #(.WORD_W(WORD_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_four_ch(cfg_four_ch), .cfg_pair_sel(cfg_pair_sel),
        .cfg_one_line(cfg_one_line),
        .adc_clk(adc_clk), .adc_convst(adc_convst), .adc_rd(adc_rd),
        .adc_cs_n(adc_cs_n), .adc_m0(adc_m0), .adc_a0(adc_a0),
        .adc_m1(adc_m1), .sample_en(sample_en), .period_end(period_end),
        .cur_idx(cur_idx)
    );

    adcrd_shift #(.WORD_W(WORD_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .sdata_a(sdata_a), .sdata_b(sdata_b),
        .full_a(full_a), .full_b(full_b)
    );

    // Split words per readout mode and compare tags with the schedule.
    always_comb begin
        word_a = adc_m1 ? full_a[2*WORD_W-1:WORD_W] : full_a[WORD_W-1:0];
        word_b = adc_m1 ? full_a[WORD_W-1:0]        : full_b;
        res_a.path = 1'b0;
        res_a.idx  = cur_idx;
        res_a.data = word_a[DATA_W-1:0];
        res_a.err  = (word_a[WORD_W-1 -: TAG_W] != {2'b10, 1'b0, cur_idx});
        res_b.path = 1'b1;
        res_b.idx  = cur_idx;
        res_b.data = word_b[DATA_W-1:0];
        res_b.err  = (word_b[WORD_W-1 -: TAG_W] != {2'b10, 1'b1, cur_idx});
    end

    adcrd_outq #(.OVF_W(OVF_W)) i_outq (
        .clk(clk), .rst_n(rst_n), .push(period_end),
        .res_a(res_a), .res_b(res_b), .ready(res_ready),
        .valid(res_valid), .res(res_q), .ovf(ovf_count)
    );

    assign res_data = res_q.data;
    assign res_path = res_q.path;
    assign res_idx  = res_q.idx;
    assign res_err  = res_q.err;
endmodule

// File: rtl/adc_pair_reader_chk.sv
// Checker for the readout controller's port protocol, bound to every instance.
module adc_pair_reader_chk #(
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_clk,
    input logic             adc_convst,
    input logic             adc_rd,
    input logic             adc_cs_n,
    input logic             adc_m0,
    input logic             adc_a0,
    input logic             adc_m1,
    input logic             res_valid,
    input logic             res_ready,
    input logic [15:0]      res_data,
    input logic             res_path,
    input logic             res_idx,
    input logic             res_err,
    input logic [OVF_W-1:0] ovf_count
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) &&
        $stable(res_path) && $stable(res_idx) && $stable(res_err)));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && !adc_rd) |->
        ($stable(adc_m0) && $stable(adc_m1) && $stable(adc_a0)));

    assert_strobe_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd) |-> ($rose(adc_convst) && !adc_cs_n && !adc_clk));

    assert_clk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && $past(!adc_cs_n)) |-> (adc_clk != $past(adc_clk)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> (!adc_clk && !adc_rd && !adc_convst));

    assert_ovf_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ovf_count >= $past(ovf_count)));
endmodule

bind adc_pair_reader adc_pair_reader_chk #(.OVF_W(OVF_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .adc_clk(adc_clk), .adc_convst(adc_convst),
    .adc_rd(adc_rd), .adc_cs_n(adc_cs_n), .adc_m0(adc_m0), .adc_a0(adc_a0),
    .adc_m1(adc_m1), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_path(res_path), .res_idx(res_idx),
    .res_err(res_err), .ovf_count(ovf_count)
);

// File: tb/test_adc_pair_reader.sv
// Bench: a converter model answers the read strobe. A scoreboard compares
// every delivered result with values computed arithmetically in the bench.
module test_adc_pair_reader;
    localparam int OVF_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
    logic cfg_four_ch = 1'b0, cfg_pair_sel = 1'b0, cfg_one_line = 1'b0;
    logic sdata_a = 1'b0, sdata_b = 1'b0, res_ready = 1'b1;
    logic adc_clk, adc_convst, adc_rd, adc_cs_n, adc_m0, adc_a0, adc_m1;
    logic res_valid, res_path, res_idx, res_err;
    logic [15:0] res_data;
    logic [OVF_W-1:0] ovf_count;

    int checks = 0, fails = 0, cyc = 0;

    adc_pair_reader #(.OVF_W(OVF_W)) i_adc_pair_reader (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_four_ch(cfg_four_ch),
        .cfg_pair_sel(cfg_pair_sel), .cfg_one_line(cfg_one_line),
        .sdata_a(sdata_a), .sdata_b(sdata_b), .adc_clk(adc_clk),
        .adc_convst(adc_convst), .adc_rd(adc_rd), .adc_cs_n(adc_cs_n),
        .adc_m0(adc_m0), .adc_a0(adc_a0), .adc_m1(adc_m1),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_path(res_path), .res_idx(res_idx), .res_err(res_err),
        .ovf_count(ovf_count)
    );

    always #5ns clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [19:0] wa = '0, wb = '0;
    int  idx = 100, per_no = 0, rd_cnt = 0;
    bit  fourtog = 0, corrupt = 0, sb_on = 1, len_on = 1;
    int  last_rd = -1;
    logic [15:0] hist_da, hist_db;
    logic [18:0] exp_q [0:255];
    int  wp = 0, rp = 0;

    always @(posedge clk) cyc++;

    task automatic drive_bits();
        if (adc_m1) begin
            if (idx < 20) sdata_a = wa[19-idx];
            else if (idx < 40) sdata_a = wb[39-idx];
            sdata_b = 1'b0;
        end else if (idx < 20) begin
            sdata_a = wa[19-idx];
            sdata_b = wb[19-idx];
        end
    endtask

    always @(posedge adc_cs_n) begin
        fourtog = 0;
        last_rd = -1;
    end

    always @(posedge adc_rd) begin
        logic mp;
        logic [15:0] da, db;
        logic [3:0]  tb_tag;
        if (adc_m0) begin mp = fourtog; fourtog = ~fourtog; end
        else begin mp = adc_a0; fourtog = 0; end
        per_no++;
        da = 16'(per_no * 4099 + 17);
        db = 16'(per_no * 2713 + 40000 + int'(mp) * 3);
        tb_tag = {2'b10, 1'b1, mp};
        if (corrupt) tb_tag = tb_tag ^ 4'b0001;
        wa = {2'b10, 1'b0, mp, da};
        wb = {tb_tag, db};
        hist_da = da;
        hist_db = db;
        idx = 0;
        drive_bits();
        if (sb_on) begin
            exp_q[wp[7:0]]       = {1'b0, mp, 1'b0, da};
            exp_q[8'(wp + 1)]    = {1'b1, mp, corrupt, db};
            wp += 2;
        end
        // R2: spacing of read strobes within an unbroken run
        if (len_on && last_rd >= 0)
            check(cyc - last_rd == (adc_m1 ? 80 : 40), "R2 period length",
                  cyc - last_rd, adc_m1 ? 80 : 40);
        last_rd = cyc;
        rd_cnt++;
    end

    always @(negedge adc_clk) if (adc_rd === 1'b0 && idx < 40) begin
        idx++;
        drive_bits();
    end

    // ---------------- scoreboard (R3 R4 R5 R6 R7 R8) ----------------
    always @(negedge clk) if (rst_n && res_valid && res_ready && sb_on) begin
        logic [18:0] e, a;
        e = exp_q[rp[7:0]];
        a = {res_path, res_idx, res_err, res_data};
        check(a == e, "R3/R4/R5/R6/R7/R8 result", int'(a), int'(e));
        rp++;
    end

    task automatic run_periods(input int k);
        int start;
        start = rd_cnt;
        run = 1'b1;
        wait (rd_cnt == start + k);
        @(negedge clk) run = 1'b0;
        wait (adc_cs_n == 1'b1);
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(adc_cs_n == 1 && adc_clk == 0 && adc_rd == 0 && adc_convst == 0,
              "R1 strobes", int'({adc_cs_n, adc_clk, adc_rd, adc_convst}), 8);
        check(res_valid == 0 && ovf_count == 0, "R1 outputs",
              int'(res_valid) + int'(ovf_count), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Sweep every configuration: R3 R4 R5 R6 R7 via the scoreboard
        for (int c = 0; c < 8; c++) begin
            cfg_four_ch  = c[2];
            cfg_one_line = c[1];
            cfg_pair_sel = c[0];
            run_periods(4);
            // R12: idle after run drops
            check(adc_cs_n == 1 && adc_clk == 0 && adc_rd == 0, "R12 idle",
                  int'({adc_cs_n, adc_clk, adc_rd}), 4);
        end
        check(rp == 64 && wp == 64, "R6/R7 result count", rp, 64);

        // R8: corrupted B tag flagged, A clean
        corrupt = 1;
        cfg_four_ch = 0; cfg_one_line = 0; cfg_pair_sel = 1;
        run_periods(1);
        corrupt = 0;
        check(rp == wp, "R8 delivered", rp, wp);

        // R9: mid-period configuration change has no effect until next period
        len_on = 0;
        cfg_four_ch = 0; cfg_one_line = 0; cfg_pair_sel = 1;
        begin
            int s;
            s = rd_cnt;
            run = 1'b1;
            wait (rd_cnt == s + 1);
            repeat (10) @(negedge clk);
            cfg_four_ch = 1; cfg_one_line = 1; cfg_pair_sel = 0;
            @(negedge clk);
            check(adc_m0 == 0 && adc_m1 == 0 && adc_a0 == 1, "R9 pins held",
                  int'({adc_m0, adc_m1, adc_a0}), 1);
            wait (rd_cnt == s + 2);
            @(negedge clk);
            check(adc_m0 == 1 && adc_m1 == 1 && adc_a0 == 0, "R9 pins updated",
                  int'({adc_m0, adc_m1, adc_a0}), 6);
            wait (rd_cnt == s + 3);
            @(negedge clk) run = 1'b0;
            wait (adc_cs_n == 1'b1);
            repeat (6) @(negedge clk);
        end
        check(rp == wp, "R5 after two-channel period", rp, wp);
        len_on = 1;

        // R10/R11: stall, drops and saturation
        sb_on = 0;
        res_ready = 1'b0;
        cfg_four_ch = 0; cfg_one_line = 0; cfg_pair_sel = 0;
        begin
            logic [15:0] first_a, first_b;
            int s;
            s = rd_cnt;
            run = 1'b1;
            wait (rd_cnt == s + 1);
            @(negedge clk);
            first_a = hist_da;
            first_b = hist_db;
            wait (rd_cnt == s + 3);
            @(negedge clk) run = 1'b0;
            wait (adc_cs_n == 1'b1);
            repeat (6) @(negedge clk);
            check(ovf_count == 4, "R11 drop count", int'(ovf_count), 4);
            check(res_valid == 1 && res_path == 0 && res_data == first_a,
                  "R10 held result", int'(res_data), int'(first_a));
            run_periods(2);
            check(ovf_count == 7, "R11 saturation", int'(ovf_count), 7);
            check(res_valid == 1 && res_data == first_a, "R10 still held",
                  int'(res_data), int'(first_a));
            res_ready = 1'b1;
            @(negedge clk);
            check(res_valid == 1 && res_path == 1 && res_data == first_b,
                  "R10 second result", int'(res_data), int'(first_b));
            @(negedge clk);
            check(res_valid == 0, "R10 drained", int'(res_valid), 0);
            check(ovf_count == 7, "R11 stays saturated", int'(ovf_count), 7);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule